// File: doc/BRIEF.md
# Flash Command Sequencer

This block runs the two modifying operations of a small on-chip nonvolatile program array: erasing one aligned page and programming one byte. Software writes a command byte into a control register. At the same moment it supplies a target address and a data byte. The sequencer captures all three values. It then holds the operation for a fixed number of clock cycles and commits the change to the array in the last cycle. Finally it clears the control register, so that no command stays armed.

The array is modelled inside the block as a register file of bytes. An erased byte reads as FFH. Programming can only turn ones into zeros, so the stored result is the old byte ANDed with the new data. A combinational read port lets software read a location back after a byte write and compare it with the intended value. Both durations are parameters counted in clock cycles. The defaults match a few milliseconds at a 50 MHz clock, and a testbench can set much shorter values.

Top module: `flash_seq`

## Requirements
- R1: After reset, busy, done and err are 0, ctrl_q reads 00H, and every array byte reads FFH on rd_data.
- R2: Writing 45H (key nibble 4H in bits 7:4, code 5H in bits 3:0) while idle starts a byte write. busy is 1 from the next cycle for exactly WRITE_CYC cycles, and ctrl_q shows 45H during that time.
- R3: Writing 4CH (key 4H, code CH) while idle starts a page erase. busy is 1 from the next cycle for exactly ERASE_CYC cycles, and ctrl_q shows 4CH during that time.
- R4: When an operation ends, busy falls, done becomes 1 and ctrl_q reads 00H in the same cycle. arr_we is high for exactly one cycle, the last busy cycle, and done is never 1 while busy is 1.
- R5: A byte write leaves the target byte equal to its previous value AND the data byte. The result is readable on rd_data at that address.
- R6: A page erase sets to FFH all 32 bytes whose address equals the supplied address with bits 4:0 forced to zero, up to that base plus 31. All other bytes are unchanged.
- R7: A command written while busy is ignored. err becomes 1 in the next cycle, and the running operation keeps its length and its effect.
- R8: A write of any other byte value while idle starts no operation. err becomes 1, busy stays 0 and ctrl_q stays 00H.
- R9: The address and data are sampled in the cycle the command is accepted. Changing addr_in or data_in later has no effect on the operation.
- R10: An accepted command clears done and err in the cycle busy rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_we | input | 1 | Write strobe for the control register |
| cmd_wdata | input | 8 | Command byte |
| addr_in | input | ADDR_W | Target address, sampled with the command |
| data_in | input | 8 | Byte to program, sampled with the command |
| rd_addr | input | ADDR_W | Read-back address |
| rd_data | output | 8 | Array content at rd_addr (combinational) |
| ctrl_q | output | 8 | Control register contents |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation finished; cleared by the next accepted command |
| err | output | 1 | Last command was rejected |
| arr_we | output | 1 | Array write strobe, one cycle at the end of an operation |
| arr_erase | output | 1 | The strobe is a page erase rather than a byte write |
| arr_addr | output | ADDR_W | Captured target (page base for an erase) |
| arr_wdata | output | 8 | Captured data byte |

## Verification
A corrupted cycle counter shows up as a busy window that is too long or too short, measured to the cycle on the first operation after the fault. A wrong captured target or opcode shows up as a wrong byte, or a wrong group of 32 bytes, at the read-back port directly after done rises. This is why every operation is followed by reads of the whole affected page and its two neighbouring bytes. A flag that fails to set or clear shows up at the first rejected or accepted command after it.

// File: rtl/fseq_pkg.sv
// Shared codes and types for the flash command sequencer.
// Assumes commands are whole bytes: a key nibble 4H over a 4-bit opcode.
package fseq_pkg;
    localparam logic [3:0] KEY_NIB   = 4'h4;
    localparam logic [3:0] OPC_ERASE = 4'hC;
    localparam logic [3:0] OPC_WRITE = 4'h5;

    typedef enum logic [1:0] {OP_NONE, OP_ERASE, OP_WRITE} op_e;

    // Map a command byte to the operation it requests.
    function automatic op_e decode_cmd(input logic [7:0] c);
        if (c[7:4] != KEY_NIB)        return OP_NONE;
        else if (c[3:0] == OPC_ERASE) return OP_ERASE;
        else if (c[3:0] == OPC_WRITE) return OP_WRITE;
        else                          return OP_NONE;
    endfunction
endpackage

// File: rtl/fseq_timer.sv
// Down-counter that marks an operation window of (load_val + 1) cycles.
// Assumes load is only pulsed while the counter is inactive.
module fseq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             active,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    // Load on start, count down while active, stop after reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (load) begin
            active <= 1'b1;
            cnt    <= load_val;
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign last = active && (cnt == '0);

    AST_TMR_NO_EARLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last) |=> active); // R2
    AST_TMR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !load) |=> !active); // R4
endmodule

// File: rtl/fseq_array.sv
// Byte-wide register file that stands in for the nonvolatile array.
// Erase sets a whole aligned page to FFH; a write can only clear bits.
module fseq_array #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    logic [7:0] mem [DEPTH];

    // Reset to erased, then apply page erase or AND-programming.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem[i] <= 8'hFF;
            else if (we && erase && ((ADDR_W'(i) >> PAGE_W) == (addr >> PAGE_W)))
                mem[i] <= 8'hFF;
            else if (we && !erase && (ADDR_W'(i) == addr))
                mem[i] <= mem[i] & wdata;
        end
    end

    assign rd_data = mem[rd_addr];

    AST_WRITE_ANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !erase) |=> mem[$past(addr)] == ($past(mem[addr]) & $past(wdata))); // R5
    AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && erase) |=> mem[$past(addr)] == 8'hFF); // R6
endmodule

// File: rtl/fseq_ctrl.sv
// Command decode and capture: accepts a command only while idle,
// captures target and data, and updates ctrl_q, done and err.
module fseq_ctrl
    import fseq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int PAGE_W    = 5,
    parameter int CNT_W     = 8,
    parameter int ERASE_CYC = 40,
    parameter int WRITE_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_wdata,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [7:0]        data_in,
    input  logic              tmr_active,
    input  logic              tmr_last,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic [7:0]        ctrl_q,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [7:0]        tgt_data,
    output logic              arr_we,
    output logic              arr_erase
);
    op_e in_op;
    op_e op_q;
    logic accept;

    // Decode the incoming byte; accept it only when no operation runs.
    always_comb begin
        in_op   = decode_cmd(cmd_wdata);
        accept  = cmd_we && !tmr_active && (in_op != OP_NONE);
        tmr_val = (in_op == OP_ERASE) ? CNT_W'(ERASE_CYC - 1) : CNT_W'(WRITE_CYC - 1);
    end

    assign tmr_load = accept;

    // Capture the operation, its target and its data on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_NONE;
            tgt_addr <= '0;
            tgt_data <= '0;
        end else if (accept) begin
            op_q     <= in_op;
            tgt_data <= data_in;
            tgt_addr <= (in_op == OP_ERASE) ? {addr_in[ADDR_W-1:PAGE_W], PAGE_W'(0)} : addr_in;
        end
    end

    // Control register: holds the command while busy, clears at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl_q <= 8'h00;
        else if (accept)   ctrl_q <= cmd_wdata;
        else if (tmr_last) ctrl_q <= 8'h00;
    end

    // Status flags: done on completion, err on any rejected command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            if (accept)        done <= 1'b0;
            else if (tmr_last) done <= 1'b1;
            if (accept)        err  <= 1'b0;
            else if (cmd_we)   err  <= 1'b1;
        end
    end

    assign arr_we    = tmr_last;
    assign arr_erase = tmr_last && (op_q == OP_ERASE);

    AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmr_active) |-> (done && ctrl_q == 8'h00)); // R4
    AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && tmr_active) |=> err); // R7
    AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tmr_active) && tmr_active) |-> ($stable(tgt_addr) && $stable(tgt_data))); // R9
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_active) |-> (!done && !err)); // R10
endmodule

// File: rtl/flash_seq.sv
// Top of the flash command sequencer: control, duration timer and array.
// Assumes durations of at least one cycle and PAGE_BYTES a power of two.
module flash_seq #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 32,
    parameter int ERASE_CYC  = 250000,
    parameter int WRITE_CYC  = 125000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_wdata,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [7:0]        data_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [7:0]        ctrl_q,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              arr_we,
    output logic              arr_erase,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int MAXCYC = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
    localparam int CNT_W  = $clog2(MAXCYC + 1);

    logic             tmr_load, tmr_last;
    logic [CNT_W-1:0] tmr_val;

    fseq_ctrl #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W),
        .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .addr_in(addr_in), .data_in(data_in), .tmr_active(busy),
        .tmr_last(tmr_last), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .ctrl_q(ctrl_q), .done(done), .err(err), .tgt_addr(arr_addr),
        .tgt_data(arr_wdata), .arr_we(arr_we), .arr_erase(arr_erase)
    );

    fseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .active(busy), .last(tmr_last)
    );

    fseq_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .erase(arr_erase),
        .addr(arr_addr), .wdata(arr_wdata), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R4
    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy); // R4
endmodule

// File: tb/sim_flash_seq.sv
module sim_flash_seq;
    localparam int AW = 8;
    localparam int EC = 40;
    localparam int WC = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_we = 1'b0;
    logic [7:0]    cmd_wdata = '0;
    logic [AW-1:0] addr_in = '0;
    logic [7:0]    data_in = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data, ctrl_q, arr_wdata;
    logic          busy, done, err, arr_we, arr_erase;
    logic [AW-1:0] arr_addr;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [256];

    always #10 clk = ~clk;

    flash_seq #(.ADDR_W(AW), .PAGE_BYTES(32), .ERASE_CYC(EC), .WRITE_CYC(WC)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .addr_in(addr_in), .data_in(data_in), .rd_addr(rd_addr), .rd_data(rd_data),
        .ctrl_q(ctrl_q), .busy(busy), .done(done), .err(err), .arr_we(arr_we),
        .arr_erase(arr_erase), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_write(input logic [7:0] old, input logic [7:0] d);
        return old & d;
    endfunction

    function automatic logic [AW-1:0] page_base(input logic [AW-1:0] a);
        return {a[AW-1:5], 5'b0};
    endfunction

    task automatic chk_rd(input logic [AW-1:0] a, input string req);
        rd_addr = a;
        #1;
        check(rd_data == model[a], req, rd_data, model[a]);
    endtask

    // Run one valid command; optionally inject a command while busy.
    task automatic do_op(input logic [7:0] code, input logic [AW-1:0] a,
                         input logic [7:0] d, input bit inject);
        int n = 0;
        int wen = 0;
        int dur = (code == 8'h4C) ? EC : WC;
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = code; addr_in = a; data_in = d;
        @(negedge clk);
        cmd_we = 1'b0;
        addr_in = AW'($urandom); data_in = 8'($urandom);            // R9 disturb
        check(busy && !done && !err, "R10 start", {busy, done, err}, 3'b100);
        check(ctrl_q == code, (code == 8'h4C) ? "R3 ctrl" : "R2 ctrl", ctrl_q, code);
        while (busy && n < 10000) begin
            n++;
            if (arr_we) begin
                wen++;
                check(n == dur, "R4 strobe timing", n, dur);
            end
            cmd_we = inject && (n == 3);
            cmd_wdata = 8'h45;
            @(negedge clk);
            cmd_we = 1'b0;
            if (inject && n == 3) check(err == 1'b1, "R7 err", err, 1);
        end
        check(n == dur, (code == 8'h4C) ? "R3 length" : "R2 length", n, dur);
        check(wen == 1, "R4 one strobe", wen, 1);
        check(done == 1'b1 && ctrl_q == 8'h00, "R4 end", {done, ctrl_q}, 9'h100);
        check(err == inject, "R7 flag", err, inject);
        if (code == 8'h4C) begin
            for (int i = 0; i < 32; i++) model[page_base(a) + AW'(i)] = 8'hFF;
            for (int i = 0; i < 32; i++) chk_rd(page_base(a) + AW'(i), "R6 page");
            chk_rd(page_base(a) - 1'b1, "R6 below");
            chk_rd(page_base(a) + AW'(32), "R6 above");
        end else begin
            model[a] = exp_write(model[a], d);
            chk_rd(a, "R5 readback");
            chk_rd(a + 1'b1, "R9 neighbour");
        end
    endtask

    task automatic bad_cmd(input logic [7:0] code);
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = code;
        @(negedge clk);
        cmd_we = 1'b0;
        check(!busy && err && ctrl_q == 8'h00, "R8 invalid", {busy, err, ctrl_q}, 10'h100);
    endtask

    initial begin
        #(20 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !err && ctrl_q == 0, "R1 flags", {busy, done, err, ctrl_q}, 0);
        for (int i = 0; i < 256; i += 17) chk_rd(AW'(i), "R1 erased");

        // directed: AND programming cannot set bits
        do_op(8'h45, 8'h1F, 8'h00, 1'b0);
        do_op(8'h45, 8'h1F, 8'hFF, 1'b0);
        do_op(8'h45, 8'h40, 8'h00, 1'b0);
        do_op(8'h45, 8'h25, 8'hA5, 1'b0);
        do_op(8'h45, 8'h25, 8'h3C, 1'b0);
        // directed: erase from an unaligned address inside page 20H..3FH
        do_op(8'h4C, 8'h3F, 8'h00, 1'b0);
        // directed: top page, busy rejection
        do_op(8'h45, 8'hFF, 8'h0F, 1'b1);
        do_op(8'h4C, 8'hE3, 8'h55, 1'b1);
        bad_cmd(8'h4A);
        bad_cmd(8'h5C);
        bad_cmd(8'h00);
        do_op(8'h45, 8'h10, 8'h81, 1'b0);   // R10 clears err left by R8

        // random mix
        for (int k = 0; k < 60; k++) begin
            int r = int'($urandom_range(0, 9));
            if (r < 6)      do_op(8'h45, AW'($urandom), 8'($urandom), r == 0);
            else if (r < 9) do_op(8'h4C, AW'($urandom), 8'($urandom), r == 8);
            else            bad_cmd(8'($urandom_range(0, 63)));
        end
        for (int i = 0; i < 256; i++) chk_rd(AW'(i), "R5 final sweep");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule